// File: doc/BRIEF.md
# Keyboard Wake-on-Key Frame Detector

This block listens to the clock and data lines of a PS/2-style keyboard while the host sleeps. It runs on a slow sampling clock of about 32 kHz. Both keyboard lines pass through a synchronizer. The block counts falling edges of the keyboard clock and collects one data bit at each edge. When eleven bits have arrived, it checks the frame against a programmed key code. A frame that matches sets a sticky wake flag. A separate event enable gates that flag onto the wake output.

If the keyboard clock stays high for too long before a frame is complete, the partial frame is discarded and the bit counter restarts. This stops a stalled or glitching keyboard from producing a false wake. An active-low run control holds the whole detection path idle while it is 1. The wake flag stays set until software pulses a write-one-to-clear input.

The block carries no data stream at its edge. Every pin is a plain level or pulse, so there is no valid/ready handshake and no back-pressure. Keyboard traffic cannot be stalled, and a frame that arrives while the flag is already set simply sets it again.

Top module: `kbwake_detector`

## Requirements
- R1: After reset, `wake_flag` and `wake_evt` are 0, and the bit counter waits for the first keyboard clock fall.
- R2: Each line passes through a two-flop synchronizer. A bit is taken at every falling edge of the synchronized keyboard clock, in the order start, eight data bits with the least significant bit first, parity, stop. The counter restarts at once after the 11th bit.
- R3: A frame matches when the start bit is 0, the data byte equals `key_code`, the number of ones in the data and parity bits together is odd, and the stop bit is 1. On a match, `wake_flag` rises at the fourth rising `clk` edge, counting from the first edge that samples the 11th keyboard clock fall on the pin.
- R4: Once at least one bit of a frame has arrived, if the synchronized keyboard clock is high for 5 consecutive sampling cycles, the partial frame is dropped and the counter restarts. A high time of 4 cycles does not drop the frame.
- R5: A frame with a wrong key, wrong parity, a start bit of 1, a stop bit of 0, or one cut short by the timeout of R4 never sets `wake_flag`.
- R6: While `det_off` is 1, the synchronizer, the counter and the timeout are held at their idle state, and no bit is collected. `det_off` resets to the running value 0 when the driver holds it low.
- R7: `wake_evt` equals `wake_flag` AND `evt_en` AND NOT `det_off`.
- R8: `wake_flag` stays set until `wake_clr` is sampled high. It is then cleared on that clock edge.
- R9: If a match and `wake_clr` land on the same clock edge, the set wins and `wake_flag` ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, about 32 kHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_off | input | 1 | 1 stops the detector, 0 runs it |
| evt_en | input | 1 | Lets the wake flag reach `wake_evt` |
| key_code | input | 8 | Key code to match |
| wake_clr | input | 1 | Write-one-to-clear pulse for the flag |
| kb_clk_in | input | 1 | Keyboard clock line, asynchronous |
| kb_dat_in | input | 1 | Keyboard data line, asynchronous |
| wake_flag | output | 1 | Sticky match flag |
| wake_evt | output | 1 | Gated wake event |

## Verification
Two things can fall on the same clock edge: setting the flag on a finished matching frame, and clearing it through `wake_clr`. The bench provokes this by holding `wake_clr` high through an entire matching frame, so the clear is present on the edge where the match lands. The behavioural model gives the set priority. The bench therefore expects `wake_flag` to be 1 for exactly one cycle, and then cleared by the clear that is still held. A second overlap is checked the same way: `det_off` is raised in the middle of a frame, and the bench then confirms that the abandoned frame leaves no trace.

// File: rtl/kbw_pkg.sv
package kbw_pkg;
  localparam int KEY_BITS   = 8;
  localparam int FRAME_BITS = KEY_BITS + 3;
  localparam int TMO_DEF    = 5;
  localparam int SYNC_DEF   = 2;
endpackage

// File: rtl/kbw_sync.sv
module kbw_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    st[g] <= IDLE;
        else if (hold) st[g] <= IDLE;
        else if (g == 0) st[g] <= d;
        else           st[g] <= st[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];

  AST_SYNC_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (q == IDLE)); // R6
endmodule

// File: rtl/kbw_frame.sv
module kbw_frame #(
  parameter int NBITS = 11,
  parameter int TMO   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             off,
  input  logic             kc,
  input  logic             kd,
  output logic             done,
  output logic [NBITS-1:0] frm
);
  localparam int CW = $clog2(NBITS + 1);
  localparam int TW = $clog2(TMO + 1);
  localparam logic [CW-1:0] LAST = CW'(NBITS - 1);
  localparam logic [TW-1:0] TRIP = TW'(TMO - 1);

  logic             prv;
  logic [CW-1:0]    cnt;
  logic [TW-1:0]    tmr;
  logic [NBITS-2:0] sh;
  logic             fall;
  logic             trip;

  assign fall = prv & ~kc;
  assign trip = (cnt != '0) & kc & (tmr == TRIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv  <= 1'b1;
      cnt  <= '0;
      tmr  <= '0;
      sh   <= '0;
      done <= 1'b0;
      frm  <= '0;
    end else if (off) begin
      prv  <= 1'b1;
      cnt  <= '0;
      tmr  <= '0;
      done <= 1'b0;
    end else begin
      prv  <= kc;
      done <= 1'b0;
      if (fall) begin
        tmr <= '0;
        sh  <= {kd, sh[NBITS-2:1]};
        if (cnt == LAST) begin
          cnt  <= '0;
          done <= 1'b1;
          frm  <= {kd, sh};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (trip) begin
        cnt <= '0;
        tmr <= '0;
      end else if ((cnt != '0) && kc) begin
        tmr <= tmr + 1'b1;
      end else begin
        tmr <= '0;
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_TIMEOUT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && !off) |=> (cnt == '0) && !done); // R4
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> (cnt == '0) && !done); // R6
endmodule

// File: rtl/kbw_check.sv
module kbw_check #(
  parameter int KW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [KW+2:0] frm,
  input  logic [KW-1:0] key,
  input  logic          clr,
  output logic          flag
);
  logic hit;

  assign hit = done & ~frm[0] & frm[KW+2] &
               (frm[KW:1] == key) & (^frm[KW+1:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  AST_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R8
  AST_NO_SET_WITHOUT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !done) |=> !flag); // R5
endmodule

// File: rtl/kbwake_detector.sv
module kbwake_detector #(
  parameter int TMO_TICKS   = kbw_pkg::TMO_DEF,
  parameter int SYNC_STAGES = kbw_pkg::SYNC_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       det_off,
  input  logic                       evt_en,
  input  logic [kbw_pkg::KEY_BITS-1:0] key_code,
  input  logic                       wake_clr,
  input  logic                       kb_clk_in,
  input  logic                       kb_dat_in,
  output logic                       wake_flag,
  output logic                       wake_evt
);
  import kbw_pkg::*;

  logic [1:0]            syn;
  logic                  fdone;
  logic [FRAME_BITS-1:0] ffrm;

  kbw_sync #(.W(2), .STAGES(SYNC_STAGES), .IDLE(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .hold(det_off),
    .d({kb_clk_in, kb_dat_in}), .q(syn)
  );

  kbw_frame #(.NBITS(FRAME_BITS), .TMO(TMO_TICKS)) u_frame (
    .clk(clk), .rst_n(rst_n), .off(det_off),
    .kc(syn[1]), .kd(syn[0]), .done(fdone), .frm(ffrm)
  );

  kbw_check #(.KW(KEY_BITS)) u_check (
    .clk(clk), .rst_n(rst_n), .done(fdone), .frm(ffrm),
    .key(key_code), .clr(wake_clr), .flag(wake_flag)
  );

  assign wake_evt = wake_flag & evt_en & ~det_off;

  AST_EVT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> (evt_en && !det_off && wake_flag)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !wake_flag); // R1
endmodule

// File: tb/kbwake_detector_bench.sv
module kbwake_detector_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       det_off = 1'b0;
  logic       evt_en = 1'b0;
  logic [7:0] key_code = 8'h1C;
  logic       wake_clr = 1'b0;
  logic       kb_clk_in = 1'b1;
  logic       kb_dat_in = 1'b1;
  logic       wake_flag, wake_evt;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int flag_hi_cycles = 0;

  always #2 clk = ~clk;

  kbwake_detector u_kbwake_detector (
    .clk(clk), .rst_n(rst_n), .det_off(det_off), .evt_en(evt_en),
    .key_code(key_code), .wake_clr(wake_clr), .kb_clk_in(kb_clk_in),
    .kb_dat_in(kb_dat_in), .wake_flag(wake_flag), .wake_evt(wake_evt)
  );

  // behavioural reference model
  logic m_c1, m_c2, m_d1, m_d2, m_prv, m_done, m_flag;
  int   m_cnt, m_hi;
  logic [10:0] m_bits, m_frm;

  function automatic logic m_match(logic [10:0] f, logic [7:0] k);
    int ones = 0;
    for (int i = 1; i <= 9; i++) ones += f[i];
    return (f[0] == 1'b0) && (f[10] == 1'b1) && (f[8:1] == k) && (ones % 2 == 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_c1 = 1; m_c2 = 1; m_d1 = 1; m_d2 = 1; m_prv = 1;
      m_done = 0; m_flag = 0; m_cnt = 0; m_hi = 0; m_bits = '0; m_frm = '0;
    end else begin
      logic nd;
      if (m_done && m_match(m_frm, key_code)) m_flag = 1;
      else if (wake_clr) m_flag = 0;
      nd = 0;
      if (det_off) begin
        m_c1 = 1; m_c2 = 1; m_d1 = 1; m_d2 = 1; m_prv = 1;
        m_cnt = 0; m_hi = 0;
      end else begin
        if (m_prv && !m_c2) begin
          m_bits[m_cnt] = m_d2;
          m_hi = 0;
          if (m_cnt == 10) begin nd = 1; m_frm = m_bits; m_cnt = 0; end
          else m_cnt++;
        end else if (m_cnt != 0 && m_c2) begin
          if (m_hi == 4) begin m_cnt = 0; m_hi = 0; end
          else m_hi++;
        end else m_hi = 0;
        m_prv = m_c2; m_c2 = m_c1; m_c1 = kb_clk_in;
        m_d2 = m_d1; m_d1 = kb_dat_in;
      end
      m_done = nd;
    end
  end

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", req, cyc, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R3", wake_flag, m_flag);
      chk("R7", wake_evt, m_flag & evt_en & ~det_off);
      if (wake_flag) flag_hi_cycles++;
    end
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [10:0] mk(logic [7:0] k, bit bpar, bit bstart, bit bstop);
    logic p = ~(^k);
    if (bpar) p = ~p;
    return {~bstop, p, k, bstart};
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [10:0] f, int nbits, int hi_cyc);
    for (int i = 0; i < nbits; i++) begin
      kb_dat_in = f[i];
      kb_clk_in = 1'b1;
      idle(hi_cyc);
      kb_clk_in = 1'b0;
      idle(2);
      kb_clk_in = 1'b1;
    end
  endtask

  task automatic clear_flag();
    wake_clr = 1'b1; idle(1); wake_clr = 1'b0; idle(1);
  endtask

  initial begin
    idle(3);
    chk("R1", wake_flag, 1'b0);
    chk("R1", wake_evt, 1'b0);
    rst_n = 1'b1;
    idle(5);
    chk("R1", wake_flag, 1'b0);

    // R3: matching frame
    evt_en = 1'b1;
    send(mk(8'h1C, 0, 0, 0), 11, 2);
    idle(2);
    chk("R3", wake_flag, 1'b1);
    chk("R7", wake_evt, 1'b1);
    idle(10);
    chk("R8", wake_flag, 1'b1);
    clear_flag();
    chk("R8", wake_flag, 1'b0);

    // R5: bad frames
    send(mk(8'h1D, 0, 0, 0), 11, 2); idle(6);
    chk("R5", wake_flag, 1'b0);
    send(mk(8'h1C, 1, 0, 0), 11, 2); idle(6);
    chk("R5", wake_flag, 1'b0);
    send(mk(8'h1C, 0, 1, 0), 11, 2); idle(6);
    chk("R5", wake_flag, 1'b0);
    send(mk(8'h1C, 0, 0, 1), 11, 2); idle(6);
    chk("R5", wake_flag, 1'b0);

    // R4: timeout drops a partial frame, next full frame still matches
    send(mk(8'h1C, 0, 0, 0), 5, 2);
    idle(8);
    send(mk(8'h1C, 0, 0, 0), 11, 2); idle(6);
    chk("R4", wake_flag, 1'b1);
    clear_flag();
    // R4: partial frame then the rest of another cut short -> no hit
    send(mk(8'h1C, 0, 0, 0), 6, 2);
    idle(8);
    send(mk(8'h1C, 0, 0, 0), 5, 2);
    idle(20);
    chk("R5", wake_flag, 1'b0);
    // R4: 4-cycle highs do not abort
    send(mk(8'h1C, 0, 0, 0), 11, 4); idle(6);
    chk("R4", wake_flag, 1'b1);
    clear_flag();
    // R4: 5-cycle highs abort every bit
    send(mk(8'h1C, 0, 0, 0), 11, 6); idle(6);
    chk("R4", wake_flag, 1'b0);

    // R2: back-to-back frames, key changed between
    key_code = 8'hA5;
    send(mk(8'h1C, 0, 0, 0), 11, 2);
    send(mk(8'hA5, 0, 0, 0), 11, 2); idle(6);
    chk("R2", wake_flag, 1'b1);
    clear_flag();

    // R6: det_off mid-frame discards it
    send(mk(8'hA5, 0, 0, 0), 6, 2);
    det_off = 1'b1; idle(4);
    send(mk(8'hA5, 0, 0, 0), 11, 2); idle(4);
    chk("R6", wake_flag, 1'b0);
    det_off = 1'b0; idle(4);
    send(mk(8'hA5, 0, 0, 0), 5, 2); idle(10);
    chk("R6", wake_flag, 1'b0);

    // R7: evt_en low and det_off high gate the event
    send(mk(8'hA5, 0, 0, 0), 11, 2); idle(6);
    evt_en = 1'b0; idle(1);
    chk("R7", wake_evt, 1'b0);
    evt_en = 1'b1; idle(1);
    chk("R7", wake_evt, 1'b1);
    det_off = 1'b1; idle(1);
    chk("R7", wake_evt, 1'b0);
    chk("R8", wake_flag, 1'b1);
    det_off = 1'b0;
    clear_flag();

    // R9: clear held across the whole frame, set wins for one cycle
    flag_hi_cycles = 0;
    wake_clr = 1'b1;
    send(mk(8'hA5, 0, 0, 0), 11, 2); idle(6);
    wake_clr = 1'b0; idle(1);
    total++;
    if (flag_hi_cycles != 1) begin
      bad++;
      $display("FAIL R9: actual=%0d expected=1 high cycles", flag_hi_cycles);
    end
    chk("R9", wake_flag, 1'b0);

    idle(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule